// File: doc/BRIEF.md
# Supervisor Reset Sequencer

This block turns several reset causes into one active-low system reset. The causes are a digital undervoltage flag, a digital lockout flag for a supply that is below its minimum working level, and an asynchronous active-low manual reset request. The undervoltage and lockout flags pull the reset output low in the same cycle they are seen. The manual request first passes through a two-flop synchroniser and then has the same effect.

When every cause has cleared, the reset stays low for a fixed number of clock cycles, `DELAY_CYCLES`, and then releases. The count starts when the last cause to clear goes away. If any cause comes back during the count, the count is dropped and begins again from zero once all causes are clear. The block's own synchronous reset leaves the output low, and the output then runs one full delay. A reset-active status, the complement of the reset output, goes to a companion watchdog so that it can ignore its inputs while the system is held in reset.

Top module: `supv_reset_seq`

## Requirements
- R1: While `uv_flag_i` is 1, `sys_rst_n_o` is 0 in the same cycle, with no register in the path.
- R2: While `lockout_i` is 1, `sys_rst_n_o` is 0 in the same cycle, whatever the other inputs are.
- R3: A 0 on `mr_async_n_i` goes through two flops. A low level set up before clock edge k drives `sys_rst_n_o` to 0 after edge k+1.
- R4: Once all causes are inactive at the clock edges (undervoltage 0, lockout 0, synchronised manual reset 1), `sys_rst_n_o` stays 0 through exactly `DELAY_CYCLES` such edges and becomes 1 after the last of them.
- R5: A cause that becomes active during the hold-off count clears the count. A full `DELAY_CYCLES` of quiet edges is then needed again.
- R6: When causes overlap, the hold-off count starts only from the release of the cause that clears last.
- R7: While `rst` is 1, `sys_rst_n_o` is 0 and the synchroniser holds the released value. After `rst` falls, a full delay runs before the output releases.
- R8: `rst_active_o` is always the complement of `sys_rst_n_o`.
- R9: `DELAY_CYCLES` is at least 1. With a value of 1, the output releases after the first quiet edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the block |
| uv_flag_i | input | 1 | Undervoltage flag, 1 = supply below threshold |
| lockout_i | input | 1 | Lockout flag, 1 = supply below minimum working level |
| mr_async_n_i | input | 1 | Asynchronous manual reset request, active low |
| sys_rst_n_o | output | 1 | System reset, active low |
| rst_active_o | output | 1 | Reset-active status for the watchdog, 1 = reset held |

## Verification
A fault in the hold-off counter or the hold state shows up as a rising edge on `sys_rst_n_o` at the wrong time. The error is seen within `DELAY_CYCLES` cycles of the last cause clearing, either as a release that comes too early or too late, or as no release at all. A fault in the synchroniser moves the manual-reset effect away from its two-edge latency. Because the bench reference model predicts the output on every cycle, each of these faults is caught in the first cycle where the outputs differ. Two instances are checked in parallel, one with a delay of 5 and one with the minimum delay of 1.

// File: rtl/supv_reset_pkg.sv
package supv_reset_pkg;

    typedef struct packed {
        logic uv;
        logic lockout;
        logic manual;
    } rst_cause_t;

    typedef enum logic {
        HOLD_RELEASED = 1'b0,
        HOLD_ACTIVE   = 1'b1
    } hold_state_e;

    function automatic logic cause_present(input rst_cause_t c);
        return c.uv | c.lockout | c.manual;
    endfunction

    function automatic int unsigned cnt_width(input int unsigned delay);
        return (delay < 2) ? 1 : $clog2(delay);
    endfunction

endpackage

// File: rtl/supv_mr_sync.sv
module supv_mr_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_n_i,
    output logic sync_n_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '1;
        else     chain_q <= {chain_q[STAGES-2:0], async_n_i};
    end

    assign sync_n_o = chain_q[STAGES-1];

    // R3: synchronised level is the input seen STAGES edges earlier (two stages here)
    assert_sync_latency_R3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2)) |-> (sync_n_o == $past(async_n_i, 2)));
endmodule

// File: rtl/supv_holdoff_timer.sv
module supv_holdoff_timer
    import supv_reset_pkg::*;
#(
    parameter int unsigned DELAY_CYCLES = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic cause_i,
    output logic hold_o
);
    localparam int unsigned CW = cnt_width(DELAY_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(DELAY_CYCLES - 1);

    hold_state_e state_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || cause_i) begin
            state_q <= HOLD_ACTIVE;
            cnt_q   <= '0;
        end else if (state_q == HOLD_ACTIVE) begin
            if (cnt_q == LAST) begin
                state_q <= HOLD_RELEASED;
                cnt_q   <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign hold_o = (state_q == HOLD_ACTIVE);

    // R5: a cause restarts the count and keeps the hold
    assert_restart_R5: assert property (@(posedge clk) disable iff (rst)
        cause_i |=> (hold_o && cnt_q == '0));
    // R4: release only after the final count with no cause present
    assert_release_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(hold_o) |-> ($past(cnt_q) == LAST && !$past(cause_i)));
    // R4: once released, stays released while quiet
    assert_stay_R4: assert property (@(posedge clk) disable iff (rst)
        (!hold_o && !cause_i) |=> !hold_o);
endmodule

// File: rtl/supv_reset_seq.sv
module supv_reset_seq
    import supv_reset_pkg::*;
#(
    parameter int unsigned DELAY_CYCLES = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic uv_flag_i,
    input  logic lockout_i,
    input  logic mr_async_n_i,
    output logic sys_rst_n_o,
    output logic rst_active_o
);
    logic       mr_sync_n;
    logic       hold;
    rst_cause_t cause;

    supv_mr_sync #(.STAGES(2)) u_mr_sync (
        .clk      (clk),
        .rst      (rst),
        .async_n_i(mr_async_n_i),
        .sync_n_o (mr_sync_n)
    );

    always_comb begin
        cause.uv      = uv_flag_i;
        cause.lockout = lockout_i;
        cause.manual  = ~mr_sync_n;
    end

    supv_holdoff_timer #(.DELAY_CYCLES(DELAY_CYCLES)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .cause_i(cause_present(cause)),
        .hold_o (hold)
    );

    assign sys_rst_n_o  = ~(hold | cause_present(cause));
    assign rst_active_o = ~sys_rst_n_o;

    // R1
    assert_uv_low_R1: assert property (@(posedge clk) disable iff (rst)
        uv_flag_i |-> !sys_rst_n_o);
    // R2
    assert_lockout_low_R2: assert property (@(posedge clk) disable iff (rst)
        lockout_i |-> !sys_rst_n_o);
    // R7: first cycle after block reset still holds reset
    assert_after_init_R7: assert property (@(posedge clk)
        $past(rst) |-> !sys_rst_n_o);
    // R8
    assert_status_R8: assert property (@(posedge clk) disable iff (rst)
        rst_active_o != sys_rst_n_o);
endmodule

// File: tb/tb_supv_reset_seq.sv
module tb_supv_reset_seq;
    localparam int unsigned D_A = 5;
    localparam int unsigned D_B = 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic uv = 1'b0, lk = 1'b0, mr_n = 1'b1;
    logic rn_a, act_a, rn_b, act_b;

    int vectors = 0;
    int misses  = 0;

    // reference state: two synchroniser stages and quiet-edge count per instance
    logic s1 = 1'b1, s2 = 1'b1;
    int quiet_a = 0, quiet_b = 0;

    always #2 clk = ~clk;

    supv_reset_seq #(.DELAY_CYCLES(D_A)) dut (
        .clk(clk), .rst(rst), .uv_flag_i(uv), .lockout_i(lk),
        .mr_async_n_i(mr_n), .sys_rst_n_o(rn_a), .rst_active_o(act_a));

    supv_reset_seq #(.DELAY_CYCLES(D_B)) dut_min (
        .clk(clk), .rst(rst), .uv_flag_i(uv), .lockout_i(lk),
        .mr_async_n_i(mr_n), .sys_rst_n_o(rn_b), .rst_active_o(act_b));

    task automatic compare(input string tag);
        logic cause_now;
        logic exp_a, exp_b;
        cause_now = rst | uv | lk | ~s2;
        exp_a = !cause_now && (quiet_a >= D_A);
        exp_b = !cause_now && (quiet_b >= D_B);
        vectors += 4;
        if (rn_a !== exp_a) begin
            misses++;
            $display("FAIL %s delay5 sys_rst_n actual=%b expected=%b t=%0t", tag, rn_a, exp_a, $time);
        end
        if (rn_b !== exp_b) begin
            misses++;
            $display("FAIL %s/R9 delay1 sys_rst_n actual=%b expected=%b t=%0t", tag, rn_b, exp_b, $time);
        end
        if (act_a !== ~exp_a) begin
            misses++;
            $display("FAIL R8 delay5 rst_active actual=%b expected=%b", act_a, ~exp_a);
        end
        if (act_b !== ~exp_b) begin
            misses++;
            $display("FAIL R8 delay1 rst_active actual=%b expected=%b", act_b, ~exp_b);
        end
    endtask

    // one cycle: check settled outputs, drive new inputs, advance the model at the edge
    task automatic cyc(input logic r, input logic u, input logic l, input logic m,
                       input string tag);
        logic pre_cause;
        @(negedge clk);
        compare(tag);
        rst = r; uv = u; lk = l; mr_n = m;
        @(posedge clk);
        pre_cause = uv | lk | ~s2;
        if (rst) begin
            quiet_a = 0; quiet_b = 0; s1 = 1'b1; s2 = 1'b1;
        end else begin
            if (pre_cause) begin quiet_a = 0; quiet_b = 0; end
            else begin
                if (quiet_a < D_A) quiet_a++;
                if (quiet_b < D_B) quiet_b++;
            end
            s2 = s1; s1 = mr_n;
        end
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 1'b0, 1'b1, tag);
    endtask

    initial begin
        #1_000_000;
        misses++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        // R7: block reset, then one full delay
        for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, 1'b0, 1'b1, "R7");
        idle(8, "R7");
        // R1: undervoltage asserts at once, then delay
        cyc(1'b0, 1'b1, 1'b0, 1'b1, "R1");
        cyc(1'b0, 1'b1, 1'b0, 1'b1, "R1");
        idle(8, "R4");
        // R2: lockout overrides even with other sources idle
        for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, 1'b1, 1'b1, "R2");
        idle(8, "R4");
        // R3: manual reset through synchroniser; single-cycle pulse
        cyc(1'b0, 1'b0, 1'b0, 1'b0, "R3");
        idle(10, "R3");
        for (int i = 0; i < 4; i++) cyc(1'b0, 1'b0, 1'b0, 1'b0, "R3");
        idle(10, "R4");
        // R5: cause returns during hold-off count
        cyc(1'b0, 1'b1, 1'b0, 1'b1, "R5");
        idle(3, "R5");
        cyc(1'b0, 1'b1, 1'b0, 1'b1, "R5");
        idle(2, "R5");
        cyc(1'b0, 1'b0, 1'b1, 1'b1, "R5");
        idle(8, "R5");
        // R6: overlapping sources, manual clears last
        cyc(1'b0, 1'b1, 1'b0, 1'b0, "R6");
        cyc(1'b0, 1'b1, 1'b1, 1'b0, "R6");
        cyc(1'b0, 1'b0, 1'b1, 1'b0, "R6");
        cyc(1'b0, 1'b0, 1'b0, 1'b0, "R6");
        idle(10, "R6");
        // R6: undervoltage clears last
        cyc(1'b0, 1'b1, 1'b0, 1'b0, "R6");
        cyc(1'b0, 1'b1, 1'b0, 1'b1, "R6");
        cyc(1'b0, 1'b1, 1'b0, 1'b1, "R6");
        cyc(1'b0, 1'b1, 1'b0, 1'b1, "R6");
        idle(8, "R6");
        // R7: block reset in the middle of normal running
        cyc(1'b1, 1'b0, 1'b0, 1'b1, "R7");
        idle(8, "R7");
        // R9: alternating cause every other cycle exercises the minimum delay
        for (int i = 0; i < 6; i++) begin
            cyc(1'b0, 1'b1, 1'b0, 1'b1, "R9");
            cyc(1'b0, 1'b0, 1'b0, 1'b1, "R9");
        end
        idle(8, "R9");
        @(negedge clk);
        compare("R4");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule